// File: doc/BRIEF.md
# Looped-Back Packet Sequence Checker

This block sits on the receive side of a link self-test. A pseudorandom packet generator sends packets whose words and lengths follow pseudorandom sequences, the packets return through a loopback path, and this checker receives them as words with start and end strobes. It runs its own copies of both sequences, first aligns its data sequence to the incoming words, and reports that it is locked. From then on it compares every word and every packet length with what it predicts.

A sticky mismatch flag records the first disagreement in either data or length. The flag and the lock both fall as soon as the test-mode enable or the start bit is removed. The length-mode settings (random or fixed, and the length limit) are mirrored from the generator so that the expected length of each packet is derived by the same rule.

Top module: `pkt_loop_checker`

## Requirements
- R1: During reset, and on the first clock after reset with the block idle, `locked` and `mismatch` are 0.
- R2: While active (test-mode enable and start bit both 1), the first received word seeds the local data sequence; `locked` rises on the clock after the eighth consecutive correctly predicted word and then stays high while active.
- R3: Before lock, a word that differs from the prediction restarts alignment from that word (the correct-word count returns to zero) and does not set `mismatch`.
- R4: After lock, a received word that differs from the predicted word sets `mismatch` on the following clock; prediction continues along the expected sequence.
- R5: In fixed-length mode (`rand_len` = 0) a packet must hold `len_limit` + 3 words; after lock, an end strobe on any other count sets `mismatch`.
- R6: In random-length mode a packet must hold (L[10:0] AND `len_limit`) + 3 words, where L is a 16-bit length register seeded with 16'hACE1 while idle and advanced once at every packet end (locked or not) as L <= {L[14:0], L[15]^L[13]^L[12]^L[10]}.
- R7: Once set, `mismatch` stays 1 for as long as the block stays active, whatever data follows.
- R8: One clock with the test-mode enable or the start bit at 0 clears `locked` and `mismatch` on the next clock and restarts alignment.
- R9: While the test-mode enable is 0, received words have no effect: `locked` and `mismatch` stay 0.
- R10: Each word of the expected data stream follows the previous word w as {w[30:0], w[31]^w[21]^w[1]^w[0]}, continuing across packet boundaries.
- R11: A packet whose end strobe arrives before lock is not length-checked and cannot set `mismatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Packet test mode enable |
| run | input | 1 | Start bit mirrored from the generator |
| rand_len | input | 1 | 1 = random packet lengths, 0 = fixed |
| len_limit | input | 11 | Length field mirrored from the generator |
| rx_valid | input | 1 | A received word is present |
| rx_sop | input | 1 | First word of a packet |
| rx_eop | input | 1 | Last word of a packet |
| rx_data | input | 32 | Received word |
| locked | output | 1 | Checker aligned to the data sequence |
| mismatch | output | 1 | Sticky data or length mismatch |

## Verification
The bound assertions watch, on every clock, that idling clears both outputs, that the mismatch flag stays up while active, that it can only rise from a locked state on a received word, and that lock only rises on a received word and holds while active. Whether the lock happens after exactly the right number of words, whether a corrupted word or a wrong length actually raises the flag, and whether the random-length rule is followed can only be shown by the bench's scenarios, which drive real sequences, corrupt chosen words and lengths, and compare both outputs against a behavioural model on every clock.

// File: rtl/pkt_chk_pkg.sv
package pkt_chk_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned LEN_LFSR_W = 16;

  // Data sequence step: x^32 + x^22 + x^2 + x + 1, shift left.
  function automatic logic [DATA_W-1:0] prbs_data_next(input logic [DATA_W-1:0] s);
    return {s[DATA_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // Length sequence step: x^16 + x^14 + x^13 + x^11 + 1, shift left.
  function automatic logic [LEN_LFSR_W-1:0] prbs_len_next(input logic [LEN_LFSR_W-1:0] s);
    return {s[LEN_LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/pkt_chk_rst_sync.sv
module pkt_chk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pkt_chk_data_track.sv
module pkt_chk_data_track
  import pkt_chk_pkg::*;
#(
  parameter int unsigned LOCK_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              vld,
  input  logic [DATA_W-1:0] data,
  output logic              locked,
  output logic              data_err
);

  localparam int unsigned CNT_W = $clog2(LOCK_WORDS + 1);
  localparam logic [CNT_W-1:0] LOCK_AT = CNT_W'(LOCK_WORDS);

  logic              seeded_q, seeded_d;
  logic [DATA_W-1:0] pred_q,   pred_d;
  logic [CNT_W-1:0]  good_q,   good_d;
  logic              lock_q,   lock_d;
  logic              hit;

  assign hit      = (data == pred_q);
  assign data_err = active & vld & lock_q & ~hit;

  always_comb begin
    seeded_d = seeded_q;
    pred_d   = pred_q;
    good_d   = good_q;
    lock_d   = lock_q;
    if (!active) begin
      seeded_d = 1'b0;
      pred_d   = '0;
      good_d   = '0;
      lock_d   = 1'b0;
    end else if (vld) begin
      if (lock_q) begin
        pred_d = prbs_data_next(pred_q);
      end else if (!seeded_q) begin
        seeded_d = 1'b1;
        pred_d   = prbs_data_next(data);
        good_d   = '0;
      end else if (hit) begin
        pred_d = prbs_data_next(data);
        good_d = good_q + 1'b1;
        if (good_q + 1'b1 == LOCK_AT) begin
          lock_d = 1'b1;
        end
      end else begin
        pred_d = prbs_data_next(data);
        good_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seeded_q <= 1'b0;
      pred_q   <= '0;
      good_q   <= '0;
      lock_q   <= 1'b0;
    end else begin
      seeded_q <= seeded_d;
      pred_q   <= pred_d;
      good_q   <= good_d;
      lock_q   <= lock_d;
    end
  end

  assign locked = lock_q;

endmodule

// File: rtl/pkt_chk_len_track.sv
module pkt_chk_len_track
  import pkt_chk_pkg::*;
#(
  parameter int unsigned               LEN_W      = 11,
  parameter int unsigned               LEN_OFFSET = 3,
  parameter logic [LEN_LFSR_W-1:0]     LEN_SEED   = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             vld,
  input  logic             sop,
  input  logic             eop,
  input  logic             rand_en,
  input  logic [LEN_W-1:0] limit,
  output logic             len_err
);

  localparam int unsigned      CW      = LEN_W + 2;
  localparam logic [CW-1:0]    CNT_MAX = {CW{1'b1}};

  logic [LEN_LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [CW-1:0]         wc_q,   wc_d;
  logic [CW-1:0]         this_wc;
  logic [LEN_W-1:0]      len_field;
  logic [CW-1:0]         exp_len;

  always_comb begin
    if (sop) begin
      this_wc = CW'(1);
    end else if (wc_q == CNT_MAX) begin
      this_wc = CNT_MAX;
    end else begin
      this_wc = wc_q + 1'b1;
    end
  end

  assign len_field = rand_en ? (lfsr_q[LEN_W-1:0] & limit) : limit;
  assign exp_len   = CW'(len_field) + CW'(LEN_OFFSET);
  assign len_err   = active & vld & eop & (this_wc != exp_len);

  always_comb begin
    lfsr_d = lfsr_q;
    wc_d   = wc_q;
    if (!active) begin
      lfsr_d = LEN_SEED;
      wc_d   = '0;
    end else if (vld) begin
      wc_d = this_wc;
      if (eop) begin
        lfsr_d = prbs_len_next(lfsr_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= LEN_SEED;
      wc_q   <= '0;
    end else begin
      lfsr_q <= lfsr_d;
      wc_q   <= wc_d;
    end
  end

endmodule

// File: rtl/pkt_chk_status.sv
module pkt_chk_status (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic locked,
  input  logic data_err,
  input  logic len_err,
  output logic mismatch
);

  logic mis_q, mis_d;

  always_comb begin
    if (!active) begin
      mis_d = 1'b0;
    end else begin
      mis_d = mis_q | (locked & (data_err | len_err));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mis_q <= 1'b0;
    end else begin
      mis_q <= mis_d;
    end
  end

  assign mismatch = mis_q;

endmodule

// File: rtl/pkt_loop_checker.sv
module pkt_loop_checker
  import pkt_chk_pkg::*;
#(
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned LEN_OFFSET = 3,
  parameter int unsigned LOCK_WORDS = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              run,
  input  logic              rand_len,
  input  logic [LEN_W-1:0]  len_limit,
  input  logic              rx_valid,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic [DATA_W-1:0] rx_data,
  output logic              locked,
  output logic              mismatch
);

  logic rst_n_int;
  logic active;
  logic lock_w;
  logic data_err;
  logic len_err;

  assign active = test_en & run;

  pkt_chk_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pkt_chk_data_track #(.LOCK_WORDS(LOCK_WORDS)) i_data (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .active   (active),
    .vld      (rx_valid),
    .data     (rx_data),
    .locked   (lock_w),
    .data_err (data_err)
  );

  pkt_chk_len_track #(.LEN_W(LEN_W), .LEN_OFFSET(LEN_OFFSET)) i_len (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .active  (active),
    .vld     (rx_valid),
    .sop     (rx_sop),
    .eop     (rx_eop),
    .rand_en (rand_len),
    .limit   (len_limit),
    .len_err (len_err)
  );

  pkt_chk_status i_status (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .active   (active),
    .locked   (lock_w),
    .data_err (data_err),
    .len_err  (len_err),
    .mismatch (mismatch)
  );

  assign locked = lock_w;

endmodule

// File: rtl/pkt_loop_checker_sva.sv
module pkt_loop_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic test_en,
  input logic run,
  input logic rx_valid,
  input logic locked,
  input logic mismatch
);

  a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(test_en && run) |=> (!locked && !mismatch));

  a_r7_flag_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && run && mismatch) |=> mismatch);

  a_r11_flag_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch) |-> $past(locked));

  a_r4_flag_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch) |-> $past(rx_valid && test_en && run));

  a_r2_lock_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(rx_valid && test_en && run));

  a_r2_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && test_en && run) |=> locked);

  a_r9_disabled_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> !locked);

endmodule

bind pkt_loop_checker pkt_loop_checker_sva i_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .test_en  (test_en),
  .run      (run),
  .rx_valid (rx_valid),
  .locked   (locked),
  .mismatch (mismatch)
);

// File: tb/test_pkt_loop_checker.sv
`timescale 1ns/1ps
module test_pkt_loop_checker;

  logic        clk;
  logic        rst_n;
  logic        test_en, run, rand_len;
  logic [10:0] len_limit;
  logic        rx_valid, rx_sop, rx_eop;
  logic [31:0] rx_data;
  logic        locked, mismatch;

  int n_chk;
  int n_fail;
  int cycles;
  bit done;

  // behavioural reference state
  bit          m_seeded, m_locked, m_mis;
  logic [31:0] m_pred;
  int          m_good, m_wc;
  logic [15:0] m_len;

  // remote generator state
  logic [31:0] g_word;
  logic [15:0] g_len;

  pkt_loop_checker i_pkt_loop_checker (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .run(run),
    .rand_len(rand_len), .len_limit(len_limit), .rx_valid(rx_valid),
    .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
    .locked(locked), .mismatch(mismatch)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] nx32(input logic [31:0] w);
    return {w[30:0], w[31] ^ w[21] ^ w[1] ^ w[0]};
  endfunction

  function automatic logic [15:0] nx16(input logic [15:0] w);
    return {w[14:0], w[15] ^ w[13] ^ w[12] ^ w[10]};
  endfunction

  function automatic int want_len(input logic [15:0] l);
    if (rand_len) return int'((l[10:0] & len_limit)) + 3;
    return int'(len_limit) + 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_seeded = 0; m_locked = 0; m_mis = 0; m_pred = '0;
    m_good = 0; m_wc = 0; m_len = 16'hACE1;
  endtask

  task automatic model_clock();
    bit old_lock;
    int this_wc;
    if (!rst_n || !(test_en && run)) begin
      model_reset();
      return;
    end
    if (!rx_valid) return;
    old_lock = m_locked;
    this_wc = rx_sop ? 1 : m_wc + 1;
    if (old_lock) begin
      if (rx_data !== m_pred) m_mis = 1;
      m_pred = nx32(m_pred);
    end else if (!m_seeded) begin
      m_seeded = 1; m_good = 0; m_pred = nx32(rx_data);
    end else if (rx_data === m_pred) begin
      m_good++; m_pred = nx32(rx_data);
      if (m_good == 8) m_locked = 1;
    end else begin
      m_good = 0; m_pred = nx32(rx_data);
    end
    if (rx_eop) begin
      if (old_lock && this_wc != want_len(m_len)) m_mis = 1;
      m_len = nx16(m_len);
    end
    m_wc = this_wc;
  endtask

  // one clock: inputs already driven; wait, update model, compare every clock
  task automatic tick();
    @(negedge clk);
    model_clock();
    chk(locked === m_locked, "R2/R3 lock model", int'(locked), int'(m_locked));
    chk(mismatch === m_mis, "R4/R5/R6 flag model", int'(mismatch), int'(m_mis));
  endtask

  task automatic idle(input int n);
    rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_data = '0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic start_test();
    test_en = 1; run = 1; g_len = 16'hACE1;
    idle(1);
  endtask

  task automatic stop_test();
    run = 0;
    idle(2);
  endtask

  // send a packet of n words; bad_idx corrupts that word (-1 for none)
  task automatic send_pkt(input int n, input int bad_idx);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_sop = (i == 0); rx_eop = (i == n - 1);
      rx_data = g_word ^ ((i == bad_idx) ? 32'h0000_0100 : 32'h0);
      g_word = nx32(g_word);
      tick();
    end
    g_len = nx16(g_len);
    idle(2);
  endtask

  task automatic send_good();
    send_pkt(want_len(g_len), -1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 0; test_en = 0; run = 0; rand_len = 0; len_limit = 11'd5;
    rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_data = '0;
    g_word = 32'h1234_5678; g_len = 16'hACE1;
    model_reset();
    repeat (3) @(negedge clk);
    chk(locked === 0 && mismatch === 0, "R1 reset", int'({locked, mismatch}), 0);
    rst_n = 1;
    idle(4);
    chk(locked === 0 && mismatch === 0, "R1 after reset", int'({locked, mismatch}), 0);

    // R9: words while disabled
    run = 1; test_en = 0;
    send_pkt(8, -1); send_pkt(8, -1);
    chk(locked === 0 && mismatch === 0, "R9 disabled ignored", int'({locked, mismatch}), 0);

    // R2 / R10: fixed length 8 words; 1 seed + 7 hits -> not locked
    stop_test(); start_test();
    send_pkt(8, -1);
    chk(locked === 0, "R2 not yet locked after 7 hits", int'(locked), 0);
    send_pkt(8, -1);
    chk(locked === 1, "R2 R10 locked after 8 hits", int'(locked), 1);
    chk(mismatch === 0, "R5 correct fixed length", int'(mismatch), 0);

    // R4 / R7: corrupt a word after lock
    send_pkt(8, 3);
    chk(mismatch === 1, "R4 data mismatch after lock", int'(mismatch), 1);
    send_good(); send_good();
    chk(mismatch === 1, "R7 flag sticky", int'(mismatch), 1);
    chk(locked === 1, "R7 lock held", int'(locked), 1);

    // R8: clear start bit
    run = 0; idle(1);
    chk(locked === 0 && mismatch === 0, "R8 start bit clears", int'({locked, mismatch}), 0);
    start_test();
    send_good(); send_good(); send_pkt(8, 2);
    chk(mismatch === 1, "R4 flag set again", int'(mismatch), 1);
    test_en = 0; idle(1);
    chk(locked === 0 && mismatch === 0, "R8 test enable clears", int'({locked, mismatch}), 0);

    // R3: corrupt a word before lock -> realign later, no flag
    run = 1; start_test();
    send_pkt(8, 5);
    chk(locked === 0 && mismatch === 0, "R3 pre-lock error ignored", int'({locked, mismatch}), 0);
    send_pkt(8, -1);
    chk(locked === 1 && mismatch === 0, "R3 realigned", int'({locked, mismatch}), 2);

    // R11: short packet before lock is not length checked
    stop_test(); start_test();
    send_pkt(4, -1);
    chk(mismatch === 0, "R11 pre-lock length ignored", int'(mismatch), 0);
    send_good(); send_good();
    chk(locked === 1 && mismatch === 0, "R11 locked clean", int'({locked, mismatch}), 2);

    // R5: long packet after lock
    send_pkt(9, -1);
    chk(mismatch === 1, "R5 long packet flagged", int'(mismatch), 1);

    // R6: random lengths
    stop_test(); rand_len = 1; len_limit = 11'h01F; start_test();
    for (int k = 0; k < 14; k++) send_good();
    chk(locked === 1 && mismatch === 0, "R6 random lengths accepted", int'({locked, mismatch}), 2);
    send_pkt(want_len(g_len) - 1, -1);
    chk(mismatch === 1, "R6 short random packet flagged", int'(mismatch), 1);

    // R6 boundary: limit 0 gives 3-word packets
    stop_test(); len_limit = 11'd0; start_test();
    for (int k = 0; k < 5; k++) send_pkt(3, -1);
    chk(locked === 1 && mismatch === 0, "R6 limit zero three words", int'({locked, mismatch}), 2);
    send_pkt(4, -1);
    chk(mismatch === 1, "R6 limit zero four words flagged", int'(mismatch), 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
      end
    end
  end

endmodule